// File: doc/BRIEF.md
# Voltage-Code Deglitch and Change Blanking

This block sits between a processor's 6-bit voltage-identification bus and the core-supply reference. The raw bits can arrive skewed against each other, so a new value is taken only after it has been held unchanged for a skew window. When it is taken, it becomes the registered code. The block also maps that code to a target level in units of 0.1 mV, which feeds the reference converter.

Every accepted change of code starts a blanking interval. Power-good and crowbar must ignore the output window comparators during this interval, because the output is still slewing to the new level. A later change restarts the interval. The block also produces a registered power-good qualifier. This qualifier combines the enable, the window-compare flags, the blanking state, and a code value that means "no processor present".

Both time windows are counted in clock cycles. The cycle counts are derived from the clock frequency in MHz and from the window lengths in nanoseconds, rounded up so that each window is never shorter than asked.

Top module: `vid_deglitch`

## Requirements
- R1: While `rst_ni` is low, `code_o`, `blank_o` and `pgood_o` are 0. On the first clock edge after release, `code_o` loads the raw `vid_i` directly, with no skew wait and no blanking.
- R2: A new raw value is accepted only after it has been held unchanged at SKEW_CYC = ceil(CLK_MHZ*SKEW_NS/1000) consecutive edges. It appears on `code_o` SKEW_CYC edges after the edge that first sampled it, which is at least 400 ns at the default settings.
- R3: If the raw value changes before its window ends, the window restarts and the abandoned value never reaches `code_o`. A bounce that returns to the accepted code changes nothing and starts no blanking.
- R4: `mv_o` gives the target in units of 0.1 mV, and `vid_i` bit 5 selects the range. When bit 5 is 0, the target is 15500 - 250*bits[4:0] (1.550 V down to 0.775 V in 25 mV steps). When bit 5 is 1, the target is 7625 - 125*bits[4:0] (0.7625 V down to 0.375 V in 12.5 mV steps).
- R5: Every accepted change of code raises `blank_o` on the accepting edge. `blank_o` then stays high for exactly BLANK_CYC = ceil(CLK_MHZ*BLANK_NS/1000) cycles. The default is 200 us.
- R6: A further accepted change during blanking restarts the count, so that `blank_o` stays high for BLANK_CYC cycles after the latest change.
- R7: `pgood_o` is registered, with one cycle of latency. It is 1 when enable is high, the code is not the no-processor code, and either `over_i` and `under_i` are both 0 or blanking is active. While blanking is active, the window flags have no effect.
- R8: When `en_i` is low, `pgood_o` is 0 on the next edge.
- R9: When `code_o` equals NOCPU_CODE (default 63), `pgood_o` is 0 on the next edge, whether or not blanking is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vid_i | input | 6 | Raw voltage-identification code |
| en_i | input | 1 | Regulator enable |
| over_i | input | 1 | Output above the power-good window |
| under_i | input | 1 | Output below the power-good window |
| code_o | output | 6 | Accepted, deglitched code |
| mv_o | output | 14 | Target level in units of 0.1 mV |
| blank_o | output | 1 | Power-good and crowbar blanking |
| pgood_o | output | 1 | Qualified power-good |

## Verification
A skew counter that is off by one moves the edge at which `code_o` takes a new value one cycle early or late. The bench samples both the cycle before and the cycle of acceptance, so it sees this on the first code change. If the blanking counter loads the wrong value, or is not reloaded on a retrigger, `blank_o` falls on the wrong cycle. This shows within one blanking interval. A wrong mapping shows on `mv_o` as soon as the code is accepted, and the sweep covers all 64 codes. A wrong power-good qualifier shows on `pgood_o` one edge after the flag or enable is applied.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int VID_W       = 6;
  localparam int LVL_W       = 14;
  localparam int COARSE_TOP  = 15500;
  localparam int COARSE_STEP = 250;
  localparam int FINE_TOP    = 7625;
  localparam int FINE_STEP   = 125;

  function automatic logic [LVL_W-1:0] code_to_level(input logic [VID_W-1:0] c);
    int idx;
    int lvl;
    idx = int'(c[VID_W-2:0]);
    if (c[VID_W-1]) lvl = FINE_TOP - FINE_STEP * idx;
    else            lvl = COARSE_TOP - COARSE_STEP * idx;
    return LVL_W'(lvl);
  endfunction
endpackage

// File: rtl/vid_skew_filter.sv
module vid_skew_filter #(
  parameter int VID_W    = 6,
  parameter int SKEW_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] code_o,
  output logic             accept_o,
  output logic             init_o
);
  localparam int CW = $clog2(SKEW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SKEW_CYC - 1);
  localparam logic [CW-1:0] DONE = CW'(SKEW_CYC);

  logic [VID_W-1:0] cand_q;
  logic [CW-1:0]    cnt_q;

  assign accept_o = init_o && (vid_i == cand_q) && (cnt_q == LAST) && (cand_q != code_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      code_o <= '0;
      cnt_q  <= '0;
      init_o <= 1'b0;
    end else if (!init_o) begin
      // first edge after reset: take raw code directly
      cand_q <= vid_i;
      code_o <= vid_i;
      cnt_q  <= DONE;
      init_o <= 1'b1;
    end else if (vid_i != cand_q) begin
      cand_q <= vid_i;
      cnt_q  <= '0;
    end else if (cnt_q != DONE) begin
      cnt_q <= cnt_q + 1'b1;
      if (accept_o) code_o <= cand_q;
    end
  end
endmodule

// File: rtl/vid_blank_timer.sv
module vid_blank_timer #(
  parameter int BLANK_CYC = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic blank_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= BW'(BLANK_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign blank_o = (cnt_q != '0);
endmodule

// File: rtl/vid_pgood_qual.sv
module vid_pgood_qual #(
  parameter int VID_W      = 6,
  parameter int NOCPU_CODE = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [VID_W-1:0] code_i,
  input  logic             over_i,
  input  logic             under_i,
  input  logic             mask_i,
  output logic             pgood_o
);
  logic cpu_ok;
  logic win_ok;

  assign cpu_ok = (code_i != VID_W'(NOCPU_CODE));
  assign win_ok = mask_i || !(over_i || under_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgood_o <= 1'b0;
    else         pgood_o <= init_i && en_i && cpu_ok && win_ok;
  end
endmodule

// File: rtl/vid_deglitch.sv
module vid_deglitch #(
  parameter int CLK_MHZ    = 125,
  parameter int SKEW_NS    = 400,
  parameter int BLANK_NS   = 200000,
  parameter int NOCPU_CODE = 63
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [vid_pkg::VID_W-1:0]  vid_i,
  input  logic                       en_i,
  input  logic                       over_i,
  input  logic                       under_i,
  output logic [vid_pkg::VID_W-1:0]  code_o,
  output logic [vid_pkg::LVL_W-1:0]  mv_o,
  output logic                       blank_o,
  output logic                       pgood_o
);
  localparam int SKEW_RAW  = (CLK_MHZ * SKEW_NS + 999) / 1000;
  localparam int BLANK_RAW = (CLK_MHZ * BLANK_NS + 999) / 1000;
  localparam int SKEW_CYC  = (SKEW_RAW < 1) ? 1 : SKEW_RAW;
  localparam int BLANK_CYC = (BLANK_RAW < 1) ? 1 : BLANK_RAW;

  logic accept_w;
  logic init_w;

  vid_skew_filter #(.VID_W(vid_pkg::VID_W), .SKEW_CYC(SKEW_CYC)) u_skew (
    .clk_i, .rst_ni, .vid_i,
    .code_o, .accept_o(accept_w), .init_o(init_w)
  );

  vid_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i, .rst_ni, .trig_i(accept_w), .blank_o
  );

  vid_pgood_qual #(.VID_W(vid_pkg::VID_W), .NOCPU_CODE(NOCPU_CODE)) u_pg (
    .clk_i, .rst_ni, .init_i(init_w), .en_i, .code_i(code_o),
    .over_i, .under_i, .mask_i(blank_o || accept_w), .pgood_o
  );

  assign mv_o = vid_pkg::code_to_level(code_o);
endmodule

// File: rtl/vid_deglitch_chk.sv
module vid_deglitch_chk #(
  parameter int NOCPU_CODE = 63
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] vid_i,
  input logic       en_i,
  input logic       over_i,
  input logic       under_i,
  input logic [5:0] code_o,
  input logic [13:0] mv_o,
  input logic       blank_o,
  input logic       pgood_o,
  input logic       init_i
);
  assert_code_from_held_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_i) && code_o != $past(code_o)) |-> code_o == $past(vid_i));

  assert_change_blanks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_i) && code_o != $past(code_o)) |-> blank_o);

  assert_level_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> (mv_o <= 14'd15500 && mv_o >= 14'd3750));

  assert_window_drops_pgood_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((over_i || under_i) && !blank_o) |=> (!pgood_o || blank_o));

  assert_enable_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pgood_o);

  assert_nocpu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == 6'(NOCPU_CODE)) |=> !pgood_o);
endmodule

bind vid_deglitch vid_deglitch_chk #(.NOCPU_CODE(NOCPU_CODE)) u_chk (
  .clk_i, .rst_ni, .vid_i, .en_i, .over_i, .under_i,
  .code_o, .mv_o, .blank_o, .pgood_o, .init_i(init_w)
);

// File: tb/tb_vid_deglitch.sv
module tb_vid_deglitch;
  localparam int S = 50;   // 125 MHz * 400 ns
  localparam int N = 500;  // 125 MHz * 4000 ns

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] vid = 6'd10;
  logic en = 1'b1, over = 1'b0, under = 1'b0;
  logic [5:0] code;
  logic [13:0] mv;
  logic blank, pgood;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vid_deglitch #(.CLK_MHZ(125), .SKEW_NS(400), .BLANK_NS(4000), .NOCPU_CODE(63)) dut (
    .clk_i(clk), .rst_ni, .vid_i(vid), .en_i(en), .over_i(over), .under_i(under),
    .code_o(code), .mv_o(mv), .blank_o(blank), .pgood_o(pgood)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_lvl(input int c);
    if (c >= 32) return 7625 - 125 * (c - 32);
    return 15500 - 250 * c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    check("R1 reset code", int'(code), 0);
    check("R1 reset blank", int'(blank), 0);
    check("R1 reset pgood", int'(pgood), 0);
    rst_ni = 1'b1;
    step(1);
    check("R1 direct load", int'(code), 10);
    check("R1 no blank", int'(blank), 0);
    step(2);
    check("R7 pgood up", int'(pgood), 1);

    // R2 skew window edge
    vid = 6'd20;
    step(S);
    check("R2 before window", int'(code), 10);
    step(1);
    check("R2 accepted", int'(code), 20);
    check("R5 blank start", int'(blank), 1);
    step(N - 1);
    check("R5 blank last", int'(blank), 1);
    step(1);
    check("R5 blank end", int'(blank), 0);

    // R7 window ignored during blank
    vid = 6'd21;
    step(S + 1);
    over = 1'b1;
    step(3);
    check("R7 masked over", int'(pgood), 1);
    step(N);
    check("R7 over unblanked", int'(pgood), 0);
    over = 1'b0;
    step(2);
    check("R7 recovered", int'(pgood), 1);

    // R6 retrigger
    vid = 6'd22;
    step(S + 1);
    step(200);
    vid = 6'd23;
    step(S + 1);
    check("R6 code", int'(code), 23);
    step(N - 1);
    check("R6 blank extended", int'(blank), 1);
    step(1);
    check("R6 blank end", int'(blank), 0);

    // R3 restart of window
    vid = 6'd24;
    step(30);
    check("R3 not yet", int'(code), 23);
    vid = 6'd25;
    step(S);
    check("R3 restarted", int'(code), 23);
    step(1);
    check("R3 final", int'(code), 25);
    step(N + 5);
    vid = 6'd26;
    step(10);
    vid = 6'd25;
    step(S + 10);
    check("R3 bounce code", int'(code), 25);
    check("R3 bounce no blank", int'(blank), 0);

    // R8 enable
    en = 1'b0;
    step(2);
    check("R8 en low", int'(pgood), 0);
    en = 1'b1;
    step(2);
    check("R8 en back", int'(pgood), 1);
    under = 1'b1;
    step(2);
    check("R7 under", int'(pgood), 0);
    under = 1'b0;

    // R9 no-cpu code
    vid = 6'd63;
    step(S + 3);
    check("R9 nocpu blanked", int'(pgood), 0);
    step(N + 2);
    check("R9 nocpu", int'(pgood), 0);

    // R4 full mapping sweep
    for (int c = 0; c < 64; c++) begin
      vid = 6'(c);
      step(S + 1);
      check("R4 code", int'(code), c);
      check("R4 level", int'(mv), exp_lvl(c));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule